// File: doc/BRIEF.md
# Event Interrupt Combiner with Write-One-to-Clear Status

This block gathers three single-cycle event pulses (a periodic tick, an alarm match and a power-fail warning) into pending bits. It drives one shared active-low interrupt line from those bits. A host reaches the block through a small 8-bit register port. There it sees which sources have fired, chooses which ones may pull the interrupt line, and acknowledges events by writing ones into the pending bits. The power-fail pending bit can also be sent to a separate active-high output on a multi-function pin. This gives the host a second and dedicated power-fail interrupt that does not depend on the shared mask.

Pending bits are set whatever the mask holds, so a source that is masked can still be polled. The mask only decides which pending bits reach the shared line. The interrupt line is a level: it stays asserted until the host clears every enabled pending bit or masks it.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset the pending, enable and routing registers are all zero, `irq_n` is high and `mfo` is low.
- R2: An event pulse on `evt_i[k]` sets pending bit k one clock later whatever the enable register holds. Bit 0 is the periodic tick, bit 1 the alarm and bit 2 the power fail. The pending bits are read at address 0, and bits 7..3 read as zero.
- R3: `irq_n` is low whenever some pending bit and the matching enable bit are both 1. It stays low, as a level, until the host clears or masks them.
- R4: A write to address 0 clears every pending bit whose data bit is 1 on the following clock. Pending bits whose data bit is 0 keep their value.
- R5: When an event pulse arrives in the same cycle as a write that clears its pending bit, the bit ends up set.
- R6: The enable register lives at address 1. Bits 2..0 are writable and readable with the same source order as the pending bits, and bits 7..3 read as zero.
- R7: Bit 0 of address 2 is the routing enable. While it is 1, `mfo` is high exactly when the power-fail pending bit is set, whatever its enable bit holds. While it is 0, `mfo` is low. Address 2 reads back the routing bit in bit 0.
- R8: Reads change no state. Address 3 reads as zero, and writes to it change nothing.
- R9: A change to the enable register takes effect on `irq_n` one clock after the write and leaves the pending bits untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 3 | Single-cycle event pulses: bit 0 periodic, bit 1 alarm, bit 2 power fail |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Shared interrupt, active low |
| mfo | output | 1 | Routed power-fail interrupt, active high |

## Verification
The assertions assume that each event input is sampled as a plain per-cycle level at the clock edge, and that a write strobe lasting several cycles is several writes. They also assume `reg_addr` and `reg_wdata` are settled before the edge where `reg_wr` is high. The bench changes every input only at the falling edge and holds it for a whole cycle. In the random phase it drives event pulses and writes freely, including writes that collide with events on the same bit. Each value is therefore always sampled cleanly at the next rising edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC  = 3;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;

    localparam int SRC_TICK  = 0;
    localparam int SRC_ALARM = 1;
    localparam int SRC_PWR   = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PENDING = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_ROUTE   = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irqc_pending_bank.sv
module irqc_pending_bank #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_en_i,
    input  logic [NUM_SRC-1:0] clr_bits_i,
    output logic [NUM_SRC-1:0] pending_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (clr_en_i && clr_bits_i[i]) begin
                bank_d.pend[i] = 1'b0;
            end
            if (evt_i[i]) begin
                bank_d.pend[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pending_o = bank_q.pend;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> pending_o[g]); // R5
        AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && clr_bits_i[g] && !evt_i[g]) |=> !pending_o[g]); // R4
        AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_i[g] && !(clr_en_i && clr_bits_i[g])) |=> $stable(pending_o[g])); // R8
    end

endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_enable_i,
    input  logic               wr_route_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] enable_o,
    output logic               route_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] enable;
        logic               route;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_enable_i) begin
            cfg_d.enable = wdata_i;
        end
        if (wr_route_i) begin
            cfg_d.route = wdata_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enable_o = cfg_q.enable;
    assign route_o  = cfg_q.route;

    AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable_i |=> $stable(enable_o)); // R6
    AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_route_i |=> $stable(route_o)); // R7

endmodule

// File: rtl/irqc_readback.sv
module irqc_readback
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int DATA_W  = 8
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] pending_i,
    input  logic [NUM_SRC-1:0] enable_i,
    input  logic               route_i,
    output logic [DATA_W-1:0]  rdata_o
);

    always_comb begin
        rdata_o = '0;
        unique case (reg_sel_e'(addr_i))
            SEL_PENDING: rdata_o = DATA_W'(pending_i);
            SEL_ENABLE:  rdata_o = DATA_W'(enable_i);
            SEL_ROUTE:   rdata_o = DATA_W'(route_i);
            SEL_NONE:    rdata_o = '0;
            default:     rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
    import irqc_pkg::*;
#(
    parameter int PWR_IDX = SRC_PWR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_n,
    output logic               mfo
);

    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] enable;
    logic               route;
    logic               wr_pending, wr_enable, wr_route;
    logic [NUM_SRC-1:0] gated;
    logic               wdata_unused;

    assign wr_pending   = reg_wr && (reg_addr == SEL_PENDING);
    assign wr_enable    = reg_wr && (reg_addr == SEL_ENABLE);
    assign wr_route     = reg_wr && (reg_addr == SEL_ROUTE);
    assign wdata_unused = ^reg_wdata[DATA_W-1:NUM_SRC];

    irqc_pending_bank #(.NUM_SRC(NUM_SRC)) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_en_i   (wr_pending),
        .clr_bits_i (reg_wdata[NUM_SRC-1:0]),
        .pending_o  (pending)
    );

    irqc_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_enable_i (wr_enable),
        .wr_route_i  (wr_route),
        .wdata_i     (reg_wdata[NUM_SRC-1:0]),
        .enable_o    (enable),
        .route_o     (route)
    );

    irqc_readback #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rb (
        .addr_i    (reg_addr),
        .pending_i (pending),
        .enable_i  (enable),
        .route_i   (route),
        .rdata_o   (reg_rdata)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        assign gated[g] = pending[g] & enable[g];
    end

    assign irq_n = ~(|gated);
    assign mfo   = route & pending[PWR_IDX];

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !reg_wr) |=> !irq_n); // R3
    AST_EVENT_ENABLED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & enable) && !wr_enable) |=> !irq_n); // R3
    AST_MFO_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[PWR_IDX] && route && !wr_route) |=> mfo); // R7
    AST_MFO_UNROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!route && !wr_route) |=> !mfo); // R7
    AST_IRQ_IDLE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_n && !mfo)); // R1

endmodule

// File: tb/irq_event_ctrl_test.sv
module irq_event_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] evt_i = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;
    logic       mfo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int m_pend = 0;
    int m_en   = 0;
    int m_rt   = 0;

    always #5 clk = ~clk;

    irq_event_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n),
        .mfo       (mfo)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_en = 0; m_rt = 0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_pend = m_pend & ~int'(reg_wdata[2:0]);
                    2'd1: m_en = int'(reg_wdata[2:0]);
                    2'd2: m_rt = int'(reg_wdata[0]);
                    default: ;
                endcase
            end
            m_pend = m_pend | int'(evt_i);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata(input int a);
        case (a)
            0: return m_pend;
            1: return m_en;
            2: return m_rt;
            default: return 0;
        endcase
    endfunction

    task automatic cyc();
        @(negedge clk);
        chk("R3", int'(irq_n), ((m_pend & m_en) != 0) ? 0 : 1);
        chk("R7", int'(mfo), (m_rt != 0 && (m_pend & 4) != 0) ? 1 : 0);
        case (reg_addr)
            2'd0: chk("R2", int'(reg_rdata), exp_rdata(0));
            2'd1: chk("R6", int'(reg_rdata), exp_rdata(1));
            2'd2: chk("R7", int'(reg_rdata), exp_rdata(2));
            default: chk("R8", int'(reg_rdata), 0);
        endcase
    endtask

    task automatic wr(input int a, input int d, input int ev);
        reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1'b1; evt_i = 3'(ev);
        cyc();
        reg_wr = 1'b0; evt_i = '0;
    endtask

    task automatic pulse(input int ev);
        evt_i = 3'(ev);
        cyc();
        evt_i = '0;
    endtask

    task automatic rd(input int a, input string req, input int exp);
        reg_addr = 2'(a);
        cyc();
        chk(req, int'(reg_rdata), exp);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        chk("R1", int'(irq_n), 1);
        chk("R1", int'(mfo), 0);
        rd(0, "R1", 0);
        rd(1, "R1", 0);
        rd(2, "R1", 0);

        // R2: events set pending bits while masked
        pulse(1);
        chk("R2", int'(irq_n), 1);
        rd(0, "R2", 1);
        pulse(2);
        pulse(4);
        rd(0, "R2", 7);

        // R9: unmasking a pending source
        wr(1, 1, 0);
        chk("R9", int'(irq_n), 0);
        rd(0, "R9", 7);

        // R3: level held
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk("R3", int'(irq_n), 0);
        end

        // R4: write-one-to-clear
        wr(0, 8'h02, 0);
        rd(0, "R4", 5);
        chk("R4", int'(irq_n), 0);
        wr(0, 8'h01, 0);
        rd(0, "R4", 4);
        chk("R4", int'(irq_n), 1);

        // R5: set wins over clear
        wr(0, 8'h04, 4);
        rd(0, "R5", 4);

        // R7: routed power-fail output, independent of enable
        wr(2, 1, 0);
        chk("R7", int'(mfo), 1);
        rd(2, "R7", 1);
        wr(0, 8'h04, 0);
        chk("R7", int'(mfo), 0);
        pulse(4);
        chk("R7", int'(mfo), 1);
        wr(2, 0, 0);
        chk("R7", int'(mfo), 0);

        // R8: reads and unmapped address have no effect
        wr(3, 8'hFF, 0);
        rd(3, "R8", 0);
        rd(0, "R8", 4);
        rd(0, "R8", 4);
        rd(1, "R8", 1);

        // R6: enable register width
        wr(1, 8'hFF, 0);
        rd(1, "R6", 7);
        chk("R6", int'(irq_n), 0);

        // mixed traffic against the reference model
        for (int i = 0; i < 400; i++) begin
            reg_addr  = 2'($urandom_range(0, 3));
            reg_wdata = 8'($urandom);
            reg_wr    = ($urandom_range(0, 3) == 0);
            evt_i     = ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'd0;
            cyc();
        end
        reg_wr = 1'b0; evt_i = '0;
        cyc();
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 20000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule